// File: doc/BRIEF.md
# Sampled Discrete PI Current Regulator

This block is the fixed-point proportional-integral regulator of a digital current loop. It runs one control iteration per modulation period. The pulse-width modulator raises a one-cycle start strobe when a period begins. On that strobe the regulator captures the reference code, the current sample taken at the start of the period, both gains and the integration-rule selector. It then forms the error, updates the integral state and publishes a new duty code with a one-cycle done strobe. Between iterations the duty code is held unchanged.

All quantities are fractional. The reference and the feedback sample are signed codes in which full scale corresponds to unity. The duty output is an unsigned fraction whose largest value corresponds to a duty cycle just below one, so it drives the modulator without any scale factor. The integral coefficient arrives already multiplied by the sampling period. The integration rule can be chosen at run time from backward Euler, forward Euler and trapezoidal. The output is clamped, and the integral state is frozen (anti-windup) while it would push the output further into saturation.

A small state machine sequences each iteration through three states. S_IDLE waits for the strobe; the transition "accept" captures the operands and moves to S_PROD. S_PROD forms the proportional term and the integral increment, and the transition "multiply" moves to S_UPDT. S_UPDT updates the integrator, the stored previous error and the duty register, and the transition "publish" returns to S_IDLE while raising done.

Top module: `pi_regulator`

## Requirements
- R1: A synchronous reset clears the duty output, the done strobe, the integral state and the stored previous error to zero.
- R2: A start strobe is accepted only in S_IDLE. A strobe that arrives while an iteration is in progress is ignored, so each accepted strobe updates the integral state exactly once.
- R3: done is a single-cycle pulse raised exactly 3 clocks after the clock edge that accepted start. duty_o changes only in the cycle done is high and otherwise holds its value.
- R4: The error is e = ref − fb, formed at full precision (DW+1 bits). The proportional term is floor(kp·e / 2^(GW−1)), where kp is a signed Q1.(GW−1) code.
- R5: Rule code 00 (backward Euler) gives the increment floor(ki·e(k) / 2^(GW−1)).
- R6: Rule code 01 (forward Euler) gives the increment floor(ki·e(k−1) / 2^(GW−1)), where e(k−1) is the error of the previous accepted iteration (zero after reset).
- R7: Rule code 10 (trapezoidal) gives the increment floor(ki·(e(k)+e(k−1)) / 2^GW).
- R8: Rule code 11 behaves exactly like code 00.
- R9: The output is v = P + I, with I the new integral state. v is clamped to the range 0 to 2^(DW−1)−1, and duty_o is the clamped v as an unsigned fraction of 2^(DW−1).
- R10: The candidate integral I' = I + inc is discarded, and I is kept, when P + I' exceeds 2^(DW−1)−1 with inc > 0, or when P + I' is below 0 with inc < 0.
- R11: ref_i and fb_i are signed two's-complement codes with DW−1 fraction bits. kp_i and ki_i are signed with GW−1 fraction bits. The rule code is captured together with the operands at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Period-start strobe from the modulator |
| ref_i | input | DW | Signed fractional reference code |
| fb_i | input | DW | Signed fractional current sample |
| kp_i | input | GW | Signed proportional gain |
| ki_i | input | GW | Signed integral coefficient (gain times period) |
| rule_i | input | 2 | Integration rule: 00 backward, 01 forward, 10 trapezoidal, 11 backward |
| duty_o | output | DW-1 | Unsigned fractional duty code |
| done_o | output | 1 | One-cycle pulse when a new duty code is published |

## Verification
The bench builds the regulator with DW=8, GW=8 and four guard bits, so an 8-bit reference and sample give a 7-bit duty code. At that size the arithmetic model in the bench can follow every iteration exactly. Sweeping all four rule codes against several proportional and integral gains, including negative and full-scale ones, under pseudo-random references drives the output into both clamps often. This exercises the anti-windup freeze, the forward rule's dependence on the previous error and the trapezoidal half-step rounding. Strobes held across a whole iteration, and resets between sweeps, show that busy strobes are ignored and that the stored previous error starts from zero.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;

    // Integration rule codes (R5..R8)
    typedef enum logic [1:0] {
        RULE_BWD  = 2'b00,
        RULE_FWD  = 2'b01,
        RULE_TRAP = 2'b10,
        RULE_ALT  = 2'b11
    } rule_e;

    // Iteration sequencer states
    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_PROD = 2'b01,
        S_UPDT = 2'b10
    } state_e;

endpackage

// File: rtl/pi_terms.sv
module pi_terms
    import pi_reg_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 16
) (
    input  logic signed [DW:0]   err,
    input  logic signed [DW:0]   err_prev,
    input  logic signed [GW-1:0] kp,
    input  logic signed [GW-1:0] ki,
    input  rule_e                rule,
    output logic signed [DW+1:0] p_term,
    output logic signed [DW+1:0] inc_term
);
    localparam int TW = DW + 2;
    localparam int MW = TW + GW;

    logic signed [TW-1:0] i_op;
    logic signed [MW-1:0] p_full;
    logic signed [MW-1:0] i_full;

    // operand of the integral product depends on the rule
    always_comb begin
        unique case (rule)
            RULE_FWD:  i_op = TW'(err_prev);
            RULE_TRAP: i_op = TW'(err) + TW'(err_prev);
            default:   i_op = TW'(err);
        endcase
    end

    assign p_full   = MW'(err) * MW'(kp);
    assign i_full   = MW'(i_op) * MW'(ki);
    assign p_term   = TW'(p_full >>> (GW - 1));
    // trapezoidal rule halves the summed errors through one extra shift
    assign inc_term = (rule == RULE_TRAP) ? TW'(i_full >>> GW)
                                          : TW'(i_full >>> (GW - 1));
endmodule

// File: rtl/pi_integ.sv
module pi_integ #(
    parameter int DW    = 16,
    parameter int GUARD = 4
) (
    input  logic signed [DW+1:0]     p_term,
    input  logic signed [DW+1:0]     inc_term,
    input  logic signed [DW+GUARD-1:0] integ,
    output logic signed [DW+GUARD-1:0] integ_next,
    output logic        [DW-2:0]     duty
);
    localparam int AW = DW + GUARD;
    localparam int UW = AW + 2;
    localparam logic signed [UW-1:0] MAXU = UW'((1 << (DW - 1)) - 1);

    logic signed [AW-1:0] cand;
    logic signed [UW-1:0] u_cand;
    logic signed [UW-1:0] v_out;
    logic                 hold;

    assign cand   = integ + AW'(inc_term);
    assign u_cand = UW'(p_term) + UW'(cand);

    // anti-windup: keep the old state when the step deepens saturation
    assign hold = ((u_cand > MAXU) && (inc_term > 0)) ||
                  ((u_cand < 0)    && (inc_term < 0));

    assign integ_next = hold ? integ : cand;
    assign v_out      = UW'(p_term) + UW'(integ_next);

    always_comb begin
        if (v_out < 0)
            duty = '0;
        else if (v_out > MAXU)
            duty = '1;
        else
            duty = v_out[DW-2:0];
    end
endmodule

// File: rtl/pi_regulator.sv
module pi_regulator
    import pi_reg_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int GUARD = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    input  logic [DW-1:0] ref_i,
    input  logic [DW-1:0] fb_i,
    input  logic [GW-1:0] kp_i,
    input  logic [GW-1:0] ki_i,
    input  logic [1:0]    rule_i,
    output logic [DW-2:0] duty_o,
    output logic          done_o
);
    localparam int EW = DW + 1;
    localparam int TW = DW + 2;
    localparam int AW = DW + GUARD;

    state_e state_q, state_d;

    logic signed [EW-1:0] err_q, err_prev_q;
    logic signed [GW-1:0] kp_q, ki_q;
    rule_e                rule_q;
    logic signed [TW-1:0] p_q, inc_q;
    logic signed [TW-1:0] p_term, inc_term;
    logic signed [AW-1:0] integ_q, integ_next;
    logic        [DW-2:0] duty_next;
    logic        [DW-2:0] duty_q;
    logic                 done_q;
    logic                 busy;

    assign busy = (state_q != S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_PROD;   // accept
            S_PROD:  state_d = S_UPDT;                // multiply
            S_UPDT:  state_d = S_IDLE;                // publish
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_IDLE;
        else       state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q      <= '0;
            err_prev_q <= '0;
            kp_q       <= '0;
            ki_q       <= '0;
            rule_q     <= RULE_BWD;
            p_q        <= '0;
            inc_q      <= '0;
            integ_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    err_q  <= {ref_i[DW-1], ref_i} - {fb_i[DW-1], fb_i};
                    kp_q   <= kp_i;
                    ki_q   <= ki_i;
                    rule_q <= rule_e'(rule_i);
                end
                S_PROD: begin
                    p_q   <= p_term;
                    inc_q <= inc_term;
                end
                S_UPDT: begin
                    integ_q    <= integ_next;
                    err_prev_q <= err_q;
                end
                default: ;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            duty_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_UPDT);
            if (state_q == S_UPDT) duty_q <= duty_next;
        end
    end

    assign duty_o = duty_q;
    assign done_o = done_q;

    pi_terms #(.DW(DW), .GW(GW)) u_terms (
        .err      (err_q),
        .err_prev (err_prev_q),
        .kp       (kp_q),
        .ki       (ki_q),
        .rule     (rule_q),
        .p_term   (p_term),
        .inc_term (inc_term)
    );

    pi_integ #(.DW(DW), .GUARD(GUARD)) u_integ (
        .p_term     (p_q),
        .inc_term   (inc_q),
        .integ      (integ_q),
        .integ_next (integ_next),
        .duty       (duty_next)
    );
endmodule

// File: rtl/pi_regulator_chk.sv
module pi_regulator_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          busy,
    input logic [DW-2:0] duty
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (duty == '0 && !done));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 3));

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty) |-> done);

    // R2
    accept_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind pi_regulator pi_regulator_chk #(.DW(DW)) u_chk (
    .clk   (clk_i),
    .rst   (rst_i),
    .start (start_i),
    .done  (done_o),
    .busy  (busy),
    .duty  (duty_o)
);

// File: tb/tb_pi_regulator.sv
module tb_pi_regulator;
    localparam int DW    = 8;
    localparam int GW    = 8;
    localparam int GUARD = 4;
    localparam int DMAX  = (1 << (DW - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] ref_c = '0;
    logic [DW-1:0] fb_c = '0;
    logic [GW-1:0] kp_c = '0;
    logic [GW-1:0] ki_c = '0;
    logic [1:0]    rule_c = 2'b00;
    logic [DW-2:0] duty;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int m_integ = 0;
    int m_eprev = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    pi_regulator #(.DW(DW), .GW(GW), .GUARD(GUARD)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .ref_i   (ref_c),
        .fb_i    (fb_c),
        .kp_i    (kp_c),
        .ki_i    (ki_c),
        .rule_i  (rule_c),
        .duty_o  (duty),
        .done_o  (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 150000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog R3: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int fdiv(input int x, input int sh);
        return x >>> sh;   // floor division by 2^sh
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state observed at the ports
        check("R1 duty after reset", int'(duty), 0);
        check("R1 done after reset", int'(done), 0);
        rst = 1'b0;
        m_integ = 0;
        m_eprev = 0;
    endtask

    // one iteration; hold_start keeps the strobe high through the whole iteration
    task automatic run_iter(input int r, input int f, input int kp, input int ki,
                            input int rule, input bit hold_start);
        int e, p, inc, cand, u, v, expd;
        bit frz, clampd;
        string tag;
        @(negedge clk);
        ref_c  = DW'(r);
        fb_c   = DW'(f);
        kp_c   = GW'(kp);
        ki_c   = GW'(ki);
        rule_c = 2'(rule);
        start  = 1'b1;
        // model (R4..R10)
        e = r - f;
        p = fdiv(kp * e, GW - 1);
        case (rule)
            1:       inc = fdiv(ki * m_eprev, GW - 1);
            2:       inc = fdiv(ki * (e + m_eprev), GW);
            default: inc = fdiv(ki * e, GW - 1);
        endcase
        cand = m_integ + inc;
        u = p + cand;
        frz = (u > DMAX && inc > 0) || (u < 0 && inc < 0);
        if (!frz) m_integ = cand;
        v = p + m_integ;
        clampd = (v < 0) || (v > DMAX);
        expd = (v < 0) ? 0 : ((v > DMAX) ? DMAX : v);
        m_eprev = e;
        if (frz)          tag = "R10 anti-windup";
        else if (clampd)  tag = "R9 clamp";
        else if (rule == 1) tag = "R6 forward";
        else if (rule == 2) tag = "R7 trapezoidal";
        else if (rule == 3) tag = "R8 alt code";
        else              tag = "R5 backward";

        @(negedge clk);
        if (!hold_start) start = 1'b0;
        check("R3 done low 1", int'(done), 0);
        @(negedge clk);
        check("R3 done low 2", int'(done), 0);
        @(negedge clk);
        start = 1'b0;
        check("R3 done pulse", int'(done), 1);
        check(tag, int'(duty), expd);
        @(negedge clk);
        // R2: strobe held while busy must not start a second iteration
        check("R2 done single", int'(done), 0);
        check("R3 duty hold", int'(duty), expd);
    endtask

    function automatic int rnd8();
        return int'($signed(lfsr[7:0]));
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        int kps[4];
        int kis[4];
        int r, f;
        kps = '{0, 32, 127, -64};
        kis = '{0, 16, 64, 127};
        do_reset();
        // R4: proportional-only with zero integral coefficient, fixed cases
        run_iter(100, -20, 64, 0, 0, 1'b0);
        run_iter(-128, 127, -128, 0, 0, 1'b0);
        run_iter(10, 10, 127, 0, 0, 1'b0);
        for (int rule = 0; rule < 4; rule++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    do_reset();
                    for (int n = 0; n < 8; n++) begin
                        step_lfsr();
                        r = rnd8();
                        step_lfsr();
                        f = rnd8() >>> 1;
                        run_iter(r, f, kps[a], kis[b], rule, (n == 3));
                    end
                end
            end
        end
        // R6: first forward step after reset uses zero previous error
        do_reset();
        run_iter(120, 0, 0, 127, 1, 1'b0);
        run_iter(0, 0, 0, 127, 1, 1'b0);
        // R11 / R10: long positive error drives into the upper clamp and back
        do_reset();
        for (int n = 0; n < 6; n++) run_iter(127, -128, 16, 127, 2, 1'b0);
        for (int n = 0; n < 6; n++) run_iter(-128, 127, 16, 127, 2, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule